// File: doc/BRIEF.md
# Saturating Hit Multiplicity Merger

This block gathers per-threshold hit flags from several parallel cluster-processing units once per bunch crossing (40 MHz) and turns them into sixteen 3-bit multiplicities. Each of the 16 thresholds gets its own count. Every unit offers two candidate slots per threshold, and the block counts the set flags across all units and candidates. A count that would exceed 7 is held at 7 rather than wrapping.

The sixteen counts are split into two halves. Thresholds 0 to 7 go into a word bound for the left-side merger, and thresholds 8 to 15 go into a word bound for the right-side merger. Each word is 25 bits long: 24 count bits plus an odd-parity bit. Both words are registered one clock after the input strobe. A sticky status bit records that some count has been clamped, and it stays set until a synchronous clear.

Top module: `hit_merger`

## Requirements
- R1: The count for threshold t is the number of set bits `unit_hits[s*16+t]` over the 16 slots s = unit*2 + candidate (8 units, 2 candidates each).
- R2: A count whose raw sum exceeds 7 is output as 7 (3'b111); it never wraps.
- R3: `left_word[23-3k:21-3k]` carries the count of threshold k, and `right_word[23-3k:21-3k]` carries the count of threshold 8+k, for k = 0..7.
- R4: Bit 24 of each word is chosen so that the word's 25 bits contain an odd number of ones.
- R5: When `in_valid` is high at a rising edge, both words show the result of that crossing after that edge, and `out_valid` is high for exactly that following cycle.
- R6: When `in_valid` is low at an edge, both words keep their previous values and `out_valid` goes low, whatever `unit_hits` carries.
- R7: `sat_flag` is set after any edge where `in_valid` is high and any threshold's raw sum exceeds 7. It stays set until an edge with `sat_clear` high and no new clamp. If a clamp and a clear happen at the same edge, the flag is set.
- R8: After a synchronous reset, both words equal 25'h1000000, and `out_valid` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Hit vector strobe for this crossing |
| unit_hits | input | 256 | Hit flags, bit (unit*2+cand)*16 + threshold |
| sat_clear | input | 1 | Synchronous clear of the sticky saturation bit |
| left_word | output | 25 | Counts of thresholds 0–7 with odd parity |
| right_word | output | 25 | Counts of thresholds 8–15 with odd parity |
| out_valid | output | 1 | Words carry a fresh crossing result |
| sat_flag | output | 1 | Sticky: some count was clamped |

## Verification
On every cycle, the assertions check odd parity on both words, the one-cycle strobe relation, and that the words hold while no strobe arrives. They also check how the sticky flag is set, held and cleared, including the case where a clamp and a clear happen together. Only the bench scenarios can show that each count lands in the right field of the right word and that the counts themselves are correct. Those scenarios drive a range of hit distributions, including sums of exactly 7, just over 7, and the full 16.

// File: rtl/hm_merge_pkg.sv
package hm_merge_pkg;
    localparam int unsigned NUM_UNITS = 8;
    localparam int unsigned CANDS     = 2;
    localparam int unsigned NUM_THR   = 16;
    localparam int unsigned CNT_W     = 3;

    localparam int unsigned SLOTS   = NUM_UNITS * CANDS;
    localparam int unsigned RAW_W   = $clog2(SLOTS + 1);
    localparam int unsigned HALF    = NUM_THR / 2;
    localparam int unsigned BODY_W  = HALF * CNT_W;
    localparam int unsigned WORD_W  = BODY_W + 1;
    localparam int unsigned HITS_W  = SLOTS * NUM_THR;
    localparam int unsigned NUM_OUT = 2;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic              par;
        logic [BODY_W-1:0] body;
    } out_word_t;

    localparam out_word_t RESET_WORD = '{par: 1'b1, body: '0};

    function automatic logic odd_par(input logic [BODY_W-1:0] d);
        return ~(^d);
    endfunction
endpackage

// File: rtl/hm_thr_counter.sv
module hm_thr_counter
    import hm_merge_pkg::*;
(
    input  logic [SLOTS-1:0] hits,
    output count_t           cnt,
    output logic             clamp
);
    logic [RAW_W-1:0] raw;

    always_comb begin
        raw = '0;
        for (int s = 0; s < int'(SLOTS); s++) begin
            raw = raw + RAW_W'(hits[s]);
        end
    end

    localparam logic [RAW_W-1:0] RAW_LIMIT = RAW_W'((1 << CNT_W) - 1);

    always_comb begin
        clamp = (raw > RAW_LIMIT);
        cnt   = clamp ? '1 : raw[CNT_W-1:0];
    end
endmodule

// File: rtl/hm_word_pack.sv
module hm_word_pack
    import hm_merge_pkg::*;
(
    input  logic [HALF-1:0][CNT_W-1:0] cnts,
    output out_word_t                  word
);
    logic [BODY_W-1:0] body;

    for (genvar k = 0; k < int'(HALF); k++) begin : g_field
        assign body[(HALF-1-k)*CNT_W +: CNT_W] = cnts[k];
    end

    always_comb begin
        word.body = body;
        word.par  = odd_par(body);
    end
endmodule

// File: rtl/hit_merger.sv
module hit_merger
    import hm_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HITS_W-1:0] unit_hits,
    input  logic              sat_clear,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              out_valid,
    output logic              sat_flag
);
    logic [NUM_THR-1:0][CNT_W-1:0] counts;
    logic [NUM_THR-1:0]            clamp_vec;
    out_word_t                     next_word [NUM_OUT];
    out_word_t                     word_q    [NUM_OUT];

    for (genvar t = 0; t < int'(NUM_THR); t++) begin : g_thr
        logic [SLOTS-1:0] slot_hits;
        for (genvar s = 0; s < int'(SLOTS); s++) begin : g_slot
            assign slot_hits[s] = unit_hits[s*NUM_THR + t];
        end
        hm_thr_counter u_cnt (
            .hits  (slot_hits),
            .cnt   (counts[t]),
            .clamp (clamp_vec[t])
        );
    end

    for (genvar h = 0; h < int'(NUM_OUT); h++) begin : g_side
        hm_word_pack u_pack (
            .cnts (counts[h*HALF +: HALF]),
            .word (next_word[h])
        );
        always_ff @(posedge clk) begin
            if (rst)           word_q[h] <= RESET_WORD;
            else if (in_valid) word_q[h] <= next_word[h];
        end
    end

    wire any_clamp = |clamp_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && any_clamp) sat_flag <= 1'b1;
            else if (sat_clear)        sat_flag <= 1'b0;
        end
    end

    assign left_word  = word_q[0];
    assign right_word = word_q[1];

    // R4: odd parity over each whole word
    p_odd_parity_r4: assert property (@(posedge clk) disable iff (rst)
        (^left_word) && (^right_word));
    // R5: strobe followed by one valid cycle
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R6: no strobe, words hold
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(left_word) && $stable(right_word)));
    // R7: clamp sets the flag, even against a clear
    p_sat_set_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any_clamp) |=> sat_flag);
    // R7: flag stays set without a clear
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clear) |=> sat_flag);
    // R7: clear without a clamp drops the flag
    p_sat_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (sat_clear && !(in_valid && any_clamp)) |=> !sat_flag);
endmodule

// File: tb/hit_merger_tb_top.sv
module hit_merger_tb_top;
    import hm_merge_pkg::*;

    localparam time CLK_PERIOD = 25ns;
    localparam int  NV = 6;

    // per-threshold raw hit numbers (0..16) for each table vector
    localparam logic [4:0] TBL [NV][16] = '{
        '{0,0,0,0,0,0,0,0, 0,0,0,0,0,0,0,0},
        '{0,1,2,3,4,5,6,7, 7,6,5,4,3,2,1,0},
        '{1,0,1,0,1,0,1,0, 0,2,0,2,0,2,0,2},
        '{7,7,7,7,7,7,7,7, 7,7,7,7,7,7,7,7},
        '{8,0,0,0,0,0,0,0, 0,0,0,0,0,0,0,3},
        '{16,9,8,7,12,0,1,15, 2,16,10,6,8,3,11,5}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [HITS_W-1:0] unit_hits = '0;
    logic              sat_clear = 1'b0;
    logic [WORD_W-1:0] left_word, right_word;
    logic              out_valid, sat_flag;

    int checks = 0;
    int errors = 0;
    logic exp_sat = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hit_merger dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .unit_hits(unit_hits),
        .sat_clear(sat_clear), .left_word(left_word), .right_word(right_word),
        .out_valid(out_valid), .sat_flag(sat_flag)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // spread n hits over distinct slots for threshold t (R1 bit layout)
    function automatic logic [HITS_W-1:0] build(input logic [4:0] raw [16]);
        logic [HITS_W-1:0] v = '0;
        for (int t = 0; t < 16; t++)
            for (int j = 0; j < int'(raw[t]); j++)
                v[((j*5 + t) % 16)*16 + t] = 1'b1;
        return v;
    endfunction

    function automatic logic [24:0] expect_word(input logic [4:0] raw [16], input int base);
        logic [24:0] w = '0;
        for (int k = 0; k < 8; k++) begin
            logic [2:0] c = (raw[base+k] > 7) ? 3'd7 : raw[base+k][2:0];
            w[23-3*k -: 3] = c;
        end
        w[24] = ~(^w[23:0]);
        return w;
    endfunction

    task automatic apply(input logic [4:0] raw [16], input logic clr, input string tag);
        logic [24:0] el, er;
        logic sat_now = 1'b0;
        for (int t = 0; t < 16; t++) if (raw[t] > 7) sat_now = 1'b1;
        el = expect_word(raw, 0);
        er = expect_word(raw, 8);
        @(negedge clk);
        unit_hits = build(raw);
        in_valid  = 1'b1;
        sat_clear = clr;
        @(posedge clk); #1;
        exp_sat = sat_now ? 1'b1 : (clr ? 1'b0 : exp_sat);
        chk(left_word  == el, {tag, " R1 R2 R3 R4 left"},  32'(left_word),  32'(el));
        chk(right_word == er, {tag, " R1 R2 R3 R4 right"}, 32'(right_word), 32'(er));
        chk(out_valid == 1'b1, {tag, " R5 out_valid"}, 32'(out_valid), 32'd1);
        chk(sat_flag == exp_sat, {tag, " R7 sat_flag"}, 32'(sat_flag), 32'(exp_sat));
        @(negedge clk);
        in_valid  = 1'b0;
        sat_clear = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [4:0] raw [16];
        logic [24:0] hl, hr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state
        chk(left_word  == 25'h1000000, "R8 left reset",  32'(left_word),  32'h1000000);
        chk(right_word == 25'h1000000, "R8 right reset", 32'(right_word), 32'h1000000);
        chk(out_valid == 1'b0, "R8 out_valid reset", 32'(out_valid), 32'd0);
        chk(sat_flag  == 1'b0, "R8 sat_flag reset",  32'(sat_flag),  32'd0);

        for (int i = 0; i < NV; i++) begin
            raw = TBL[i];
            apply(raw, 1'b0, $sformatf("vec%0d", i));
        end

        // R6: no strobe, garbage hits must not reach the words
        hl = left_word; hr = right_word;
        @(negedge clk);
        unit_hits = '1; in_valid = 1'b0;
        @(posedge clk); #1;
        chk(left_word == hl,  "R6 left held",  32'(left_word),  32'(hl));
        chk(right_word == hr, "R6 right held", 32'(right_word), 32'(hr));
        chk(out_valid == 1'b0, "R6 out_valid low", 32'(out_valid), 32'd0);

        // R7: clear alone drops the flag
        @(negedge clk);
        sat_clear = 1'b1;
        @(posedge clk); #1;
        exp_sat = 1'b0;
        chk(sat_flag == 1'b0, "R7 clear", 32'(sat_flag), 32'd0);
        @(negedge clk);
        sat_clear = 1'b0;

        // R7: clear together with a clamp leaves flag set
        raw = TBL[4];
        apply(raw, 1'b1, "r7_set_wins");
        // R7: clear together with non-clamping crossing drops it
        raw = TBL[3];
        apply(raw, 1'b1, "r7_clear_no_clamp");
        // R7: flag stays set across idle cycles
        raw = TBL[5];
        apply(raw, 1'b0, "r7_set_again");
        repeat (3) @(posedge clk);
        #1;
        chk(sat_flag == 1'b1, "R7 sticky idle", 32'(sat_flag), 32'd1);

        // R8: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(sat_flag == 1'b0 && left_word == 25'h1000000, "R8 reset again",
            32'(left_word), 32'h1000000);
        @(negedge clk);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule